// File: doc/BRIEF.md
# Port 80h POST Code Ring Logger

This block watches host I/O writes and, when a write targets port 80h, stores the written byte into an internal byte ring. The ring is bounded by two programmable indices (a low and a high index, inclusive). A current index marks the slot the next code will land in. After each capture the index moves forward by one and folds back to the low index once it has written the high index. Embedded firmware reads the current index and compares it with the value it saw last time, so it can drain every code logged since then.

Each capture sets a sticky full flag, which can raise an interrupt. Software clears the flag by writing a one. A small register file on the internal side holds the control bits, the two bounds, the current index, the status flag and an indirect window into the ring. A capture happens only when both the logger enable bit and the cycle-accept bit are set. An access-mode field set to 10b locks the internal side out of changing the ring, the bounds and the index. The control, status and pointer registers stay writable, so firmware can always leave that mode.

Top module: `postlog_ring`

## Requirements
- R1: A capture stores the host byte into the ring slot named by the current index. At the same clock edge the current index advances by one.
- R2: When a capture writes the slot equal to the high index, the current index returns to the low index. The low index (register 1) and the high index (register 2) are both programmable, and the span they give is inclusive.
- R3: Register 3 reads the current index zero-extended to 8 bits. Writes to registers 1, 2, 3 and 5 keep only the low IDX_W bits.
- R4: A capture needs all of the following: host_wr high, host_addr equal to 0x0080, control bit 0 (enable) set and control bit 1 (accept) set. Any other host write leaves the ring, the current index and the full flag unchanged.
- R5: Every capture sets the full flag (register 4, bit 0). The flag stays set until software writes register 4 with bit 0 high. If a capture and a clear land in the same cycle, the flag stays set.
- R6: irq is high exactly when the full flag is set and control bit 4 (interrupt enable) is set.
- R7: While control bits 3:2 equal 10b, internal-side writes to register 1 (low), register 2 (high), register 3 (current index) and register 6 (ring data) have no effect. Writes to register 0 (control), register 4 (status) and register 5 (pointer) still take effect. Host captures continue in this mode.
- R8: After reset, the control register reads 0, the low index is 0 and the high index is DEPTH-1. The current index equals the low index, and the full flag is clear.
- R9: Register 6 reads the ring byte at the pointer held in register 5. A write to register 6 stores a byte at that pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host I/O write strobe, one cycle per write |
| host_addr | input | HOST_AW | Host I/O address |
| host_wdata | input | 8 | Host write byte |
| reg_wr | input | 1 | Internal register write strobe |
| reg_addr | input | 3 | Internal register select |
| reg_wdata | input | 8 | Internal register write data |
| reg_rdata | output | 8 | Internal register read data, combinational on reg_addr |
| irq | output | 1 | Input-buffer-full interrupt |

## Verification
The bench sweeps every pair of low and high indices with low at or below high on a 16-entry ring. For each pair it drives one capture more than the span holds. A design with an off-by-one fold would skip the high slot or run past it, and one that wraps to zero would land outside the span. It also sends port 80h writes with only one of the two gating bits set, and writes to a neighbouring address. A design with loose gating would move the index there. The remaining checks cover the locked access mode, including leaving that mode through the control register, and the stickiness of the full flag. A design that clears the flag on any status write, or that locks the control register, shows a wrong readback.

// File: rtl/postlog_pkg.sv
package postlog_pkg;

    typedef enum logic [2:0] {
        RA_CTRL  = 3'd0,
        RA_LO    = 3'd1,
        RA_HI    = 3'd2,
        RA_CUR   = 3'd3,
        RA_STAT  = 3'd4,
        RA_PTR   = 3'd5,
        RA_DATA  = 3'd6,
        RA_NONE  = 3'd7
    } reg_addr_e;

    localparam logic [1:0] MODE_LOCKED = 2'b10;
    localparam logic [7:0] CTRL_MASK   = 8'h1F;

    typedef struct packed {
        logic [2:0] rsvd;
        logic       irq_en;
        logic [1:0] mode;
        logic       accept;
        logic       enable;
    } ctrl_t;

    function automatic logic [7:0] ring_next(input logic [7:0] cur,
                                             input logic [7:0] lo,
                                             input logic [7:0] hi);
        return (cur == hi) ? lo : cur + 8'd1;
    endfunction

endpackage

// File: rtl/postlog_decode.sv
module postlog_decode
    import postlog_pkg::*;
#(
    parameter int                 HOST_AW = 16,
    parameter logic [HOST_AW-1:0] PORT    = 16'h0080
) (
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    input  ctrl_t              ctrl,
    output logic               cap
);

    logic hit;

    always_comb begin
        hit = host_wr && (host_addr == PORT);
        cap = hit && ctrl.enable && ctrl.accept;
    end

endmodule

// File: rtl/postlog_index.sv
module postlog_index
    import postlog_pkg::*;
#(
    parameter int               IDX_W     = 8,
    parameter logic [IDX_W-1:0] BEGIN_RST = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap,
    input  logic             cur_ld,
    input  logic [IDX_W-1:0] cur_ld_val,
    input  logic [IDX_W-1:0] lo_idx,
    input  logic [IDX_W-1:0] hi_idx,
    output logic [IDX_W-1:0] cur_idx
);

    logic [IDX_W-1:0] nxt;

    always_comb begin
        nxt = IDX_W'(ring_next(8'(cur_idx), 8'(lo_idx), 8'(hi_idx)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_idx <= BEGIN_RST;
        end else if (cap) begin
            cur_idx <= nxt;
        end else if (cur_ld) begin
            cur_idx <= cur_ld_val;
        end
    end

endmodule

// File: rtl/postlog_store.sv
module postlog_store #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             cap,
    input  logic [IDX_W-1:0] cap_idx,
    input  logic [7:0]       cap_data,
    input  logic             sw_we,
    input  logic [IDX_W-1:0] sw_idx,
    input  logic [7:0]       sw_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data
);

    localparam int DEPTH = 1 << IDX_W;

    logic [7:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        logic [7:0] byte_q;
        logic       cap_hit;
        logic       sw_hit;

        always_comb begin
            cap_hit = cap && (cap_idx == IDX_W'(g));
            sw_hit  = sw_we && (sw_idx == IDX_W'(g));
        end

        always_ff @(posedge clk) begin
            if (cap_hit) begin
                byte_q <= cap_data;
            end else if (sw_hit) begin
                byte_q <= sw_data;
            end
        end

        assign cells[g] = byte_q;
    end

    assign rd_data = cells[rd_idx];

endmodule

// File: rtl/postlog_regs.sv
module postlog_regs
    import postlog_pkg::*;
#(
    parameter int               IDX_W     = 8,
    parameter logic [IDX_W-1:0] BEGIN_RST = '0,
    parameter logic [IDX_W-1:0] END_RST   = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    input  logic             cap,
    input  logic [IDX_W-1:0] cur_idx,
    input  logic [7:0]       ram_rdata,
    output ctrl_t            ctrl,
    output logic [IDX_W-1:0] lo_idx,
    output logic [IDX_W-1:0] hi_idx,
    output logic [IDX_W-1:0] ptr_idx,
    output logic             full,
    output logic             cur_ld,
    output logic [IDX_W-1:0] cur_ld_val,
    output logic             sw_we,
    output logic [7:0]       reg_rdata
);

    reg_addr_e        ra;
    logic             locked;
    logic [IDX_W-1:0] wr_idx;

    always_comb begin
        ra         = reg_addr_e'(reg_addr);
        locked     = (ctrl.mode == MODE_LOCKED);
        wr_idx     = IDX_W'(reg_wdata);
        cur_ld     = reg_wr && (ra == RA_CUR) && !locked;
        cur_ld_val = wr_idx;
        sw_we      = reg_wr && (ra == RA_DATA) && !locked;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            lo_idx  <= BEGIN_RST;
            hi_idx  <= END_RST;
            ptr_idx <= '0;
        end else if (reg_wr) begin
            unique case (ra)
                RA_CTRL: ctrl    <= ctrl_t'(reg_wdata & CTRL_MASK);
                RA_LO:   if (!locked) lo_idx <= wr_idx;
                RA_HI:   if (!locked) hi_idx <= wr_idx;
                RA_PTR:  ptr_idx <= wr_idx;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
        end else if (cap) begin
            full <= 1'b1;
        end else if (reg_wr && (ra == RA_STAT) && reg_wdata[0]) begin
            full <= 1'b0;
        end
    end

    always_comb begin
        unique case (ra)
            RA_CTRL: reg_rdata = ctrl;
            RA_LO:   reg_rdata = 8'(lo_idx);
            RA_HI:   reg_rdata = 8'(hi_idx);
            RA_CUR:  reg_rdata = 8'(cur_idx);
            RA_STAT: reg_rdata = {7'd0, full};
            RA_PTR:  reg_rdata = 8'(ptr_idx);
            RA_DATA: reg_rdata = ram_rdata;
            default: reg_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/postlog_ring.sv
module postlog_ring
    import postlog_pkg::*;
#(
    parameter int                 IDX_W     = 8,
    parameter int                 HOST_AW   = 16,
    parameter logic [HOST_AW-1:0] PORT      = 16'h0080,
    parameter logic [IDX_W-1:0]   BEGIN_RST = '0,
    parameter logic [IDX_W-1:0]   END_RST   = '1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [7:0]         host_wdata,
    input  logic               reg_wr,
    input  logic [2:0]         reg_addr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    output logic               irq
);

    ctrl_t            ctrl;
    logic             cap;
    logic             full;
    logic             cur_ld;
    logic             sw_we;
    logic [IDX_W-1:0] cur_idx;
    logic [IDX_W-1:0] cur_ld_val;
    logic [IDX_W-1:0] lo_idx;
    logic [IDX_W-1:0] hi_idx;
    logic [IDX_W-1:0] ptr_idx;
    logic [7:0]       ram_rdata;

    postlog_decode #(.HOST_AW(HOST_AW), .PORT(PORT)) u_decode (
        .host_wr   (host_wr),
        .host_addr (host_addr),
        .ctrl      (ctrl),
        .cap       (cap)
    );

    postlog_regs #(.IDX_W(IDX_W), .BEGIN_RST(BEGIN_RST), .END_RST(END_RST)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .cap        (cap),
        .cur_idx    (cur_idx),
        .ram_rdata  (ram_rdata),
        .ctrl       (ctrl),
        .lo_idx     (lo_idx),
        .hi_idx     (hi_idx),
        .ptr_idx    (ptr_idx),
        .full       (full),
        .cur_ld     (cur_ld),
        .cur_ld_val (cur_ld_val),
        .sw_we      (sw_we),
        .reg_rdata  (reg_rdata)
    );

    postlog_index #(.IDX_W(IDX_W), .BEGIN_RST(BEGIN_RST)) u_index (
        .clk        (clk),
        .rst        (rst),
        .cap        (cap),
        .cur_ld     (cur_ld),
        .cur_ld_val (cur_ld_val),
        .lo_idx     (lo_idx),
        .hi_idx     (hi_idx),
        .cur_idx    (cur_idx)
    );

    postlog_store #(.IDX_W(IDX_W)) u_store (
        .clk      (clk),
        .cap      (cap),
        .cap_idx  (cur_idx),
        .cap_data (host_wdata),
        .sw_we    (sw_we),
        .sw_idx   (ptr_idx),
        .sw_data  (reg_wdata),
        .rd_idx   (ptr_idx),
        .rd_data  (ram_rdata)
    );

    assign irq = full && ctrl.irq_en;

endmodule

// File: rtl/postlog_ring_chk.sv
module postlog_ring_chk
    import postlog_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_wr,
    input logic [2:0]       reg_addr,
    input logic [7:0]       reg_wdata,
    input logic             irq,
    input logic             cap,
    input logic [IDX_W-1:0] cur_idx,
    input logic [IDX_W-1:0] lo_idx,
    input logic [IDX_W-1:0] hi_idx,
    input logic             full,
    input ctrl_t            ctrl
);

    logic locked;
    logic sw_cur;
    logic clr_req;

    always_comb begin
        locked  = (ctrl.mode == 2'b10);
        sw_cur  = reg_wr && (reg_addr == 3'd3) && !locked;
        clr_req = reg_wr && (reg_addr == 3'd4) && reg_wdata[0];
    end

    // R1: index steps by one inside the span
    assert_step_R1: assert property (@(posedge clk) disable iff (rst)
        (cap && (cur_idx != hi_idx)) |=> (cur_idx == IDX_W'($past(cur_idx) + 1'b1)));

    // R2: fold to low bound after the high slot
    assert_fold_R2: assert property (@(posedge clk) disable iff (rst)
        (cap && (cur_idx == hi_idx)) |=> (cur_idx == $past(lo_idx)));

    // R4: no capture and no software load keeps the index
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!cap && !sw_cur) |=> (cur_idx == $past(cur_idx)));

    // R4: gating bits off means no flag rise
    assert_gate_R4: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.enable || !ctrl.accept) |=> !$rose(full));

    // R5: capture sets the flag
    assert_set_R5: assert property (@(posedge clk) disable iff (rst)
        cap |=> full);

    // R5: flag is sticky without a clear
    assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (full && !clr_req) |=> full);

    // R6: no interrupt without the flag
    assert_irq_R6: assert property (@(posedge clk) disable iff (rst)
        !full |-> !irq);

    // R7: locked mode protects the bounds
    assert_lock_R7: assert property (@(posedge clk) disable iff (rst)
        (locked && reg_wr && ((reg_addr == 3'd1) || (reg_addr == 3'd2)))
        |=> ((lo_idx == $past(lo_idx)) && (hi_idx == $past(hi_idx))));

endmodule

bind postlog_ring postlog_ring_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq       (irq),
    .cap       (cap),
    .cur_idx   (cur_idx),
    .lo_idx    (lo_idx),
    .hi_idx    (hi_idx),
    .full      (full),
    .ctrl      (ctrl)
);

// File: tb/postlog_ring_bench.sv
module postlog_ring_bench;

    localparam int IDX_W = 4;
    localparam int DEPTH = 1 << IDX_W;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_LO   = 3'd1;
    localparam logic [2:0] A_HI   = 3'd2;
    localparam logic [2:0] A_CUR  = 3'd3;
    localparam logic [2:0] A_STAT = 3'd4;
    localparam logic [2:0] A_PTR  = 3'd5;
    localparam logic [2:0] A_DATA = 3'd6;

    // control: bit0 enable, bit1 accept, bits3:2 mode, bit4 irq enable
    localparam logic [7:0] C_RUN  = 8'h13;
    localparam logic [7:0] C_LOCK = 8'h1B;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic [15:0] host_addr = 16'h0000;
    logic [7:0]  host_wdata = 8'h00;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd7;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        irq;

    int   total = 0;
    int   bad   = 0;
    bit   done  = 1'b0;
    logic [7:0] model [DEPTH];
    int   exp_cur;
    logic [7:0] rd;
    logic [7:0] code;

    always #10 clk = ~clk;

    postlog_ring #(.IDX_W(IDX_W)) u_postlog_ring (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq        (irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 3'd7;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        reg_addr = 3'd7;
    endtask

    task automatic host(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0; host_addr = 16'h0000;
    endtask

    task automatic cap_and_track(input int lo, input int hi, input logic [7:0] d);
        host(16'h0080, d);
        model[exp_cur] = d;
        exp_cur = (exp_cur == hi) ? lo : ((exp_cur + 1) % DEPTH);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R8: reset state
        rd_reg(A_CTRL, rd); chk("R8 ctrl", rd, 8'h00);
        rd_reg(A_LO, rd);   chk("R8 lo", rd, 8'h00);
        rd_reg(A_HI, rd);   chk("R8 hi", rd, 8'(DEPTH - 1));
        rd_reg(A_CUR, rd);  chk("R8 cur", rd, 8'h00);
        rd_reg(A_STAT, rd); chk("R8 full", rd, 8'h00);
        chk("R8 irq", {7'd0, irq}, 8'h00);

        // R9: fill every slot through the data window and read back
        for (int i = 0; i < DEPTH; i++) begin
            wr_reg(A_PTR, 8'(i));
            wr_reg(A_DATA, 8'(8'hA0 + i));
            model[i] = 8'(8'hA0 + i);
        end
        for (int i = 0; i < DEPTH; i++) begin
            wr_reg(A_PTR, 8'(i));
            rd_reg(A_DATA, rd); chk("R9 data window", rd, model[i]);
        end

        // R4: gating, each partial setting ignored
        host(16'h0080, 8'h11);
        rd_reg(A_CUR, rd);  chk("R4 disabled cur", rd, 8'h00);
        rd_reg(A_STAT, rd); chk("R4 disabled full", rd, 8'h00);
        wr_reg(A_CTRL, 8'h01);
        host(16'h0080, 8'h12);
        rd_reg(A_CUR, rd);  chk("R4 no accept cur", rd, 8'h00);
        wr_reg(A_CTRL, 8'h02);
        host(16'h0080, 8'h13);
        rd_reg(A_CUR, rd);  chk("R4 no enable cur", rd, 8'h00);
        wr_reg(A_CTRL, C_RUN);
        host(16'h0081, 8'h14);
        rd_reg(A_CUR, rd);  chk("R4 other addr cur", rd, 8'h00);
        rd_reg(A_STAT, rd); chk("R4 other addr full", rd, 8'h00);
        wr_reg(A_PTR, 8'h00);
        rd_reg(A_DATA, rd); chk("R4 slot untouched", rd, model[0]);
        chk("R6 irq idle", {7'd0, irq}, 8'h00);

        // R1 R5 R6: first capture
        exp_cur = 0;
        cap_and_track(0, DEPTH - 1, 8'h5A);
        rd_reg(A_CUR, rd);  chk("R1 advance", rd, 8'(exp_cur));
        rd_reg(A_DATA, rd); chk("R1 stored", rd, 8'h5A);
        rd_reg(A_STAT, rd); chk("R5 set", rd, 8'h01);
        chk("R6 irq on", {7'd0, irq}, 8'h01);
        wr_reg(A_STAT, 8'h00);
        rd_reg(A_STAT, rd); chk("R5 zero write keeps", rd, 8'h01);
        wr_reg(A_CTRL, 8'h03);
        chk("R6 irq masked", {7'd0, irq}, 8'h00);
        wr_reg(A_CTRL, C_RUN);
        wr_reg(A_STAT, 8'h01);
        rd_reg(A_STAT, rd); chk("R5 cleared", rd, 8'h00);
        chk("R6 irq off", {7'd0, irq}, 8'h00);

        // R5: capture and clear in the same cycle, set wins
        @(negedge clk);
        host_wr = 1'b1; host_addr = 16'h0080; host_wdata = 8'h77;
        reg_wr = 1'b1; reg_addr = A_STAT; reg_wdata = 8'h01;
        @(negedge clk);
        host_wr = 1'b0; host_addr = 16'h0000; reg_wr = 1'b0; reg_addr = 3'd7;
        model[exp_cur] = 8'h77;
        exp_cur = exp_cur + 1;
        rd_reg(A_STAT, rd); chk("R5 set beats clear", rd, 8'h01);
        wr_reg(A_STAT, 8'h01);

        // R3: masking of index writes and readback
        wr_reg(A_CUR, 8'hF7);
        rd_reg(A_CUR, rd); chk("R3 cur masked", rd, 8'h07);
        wr_reg(A_LO, 8'hFE);
        rd_reg(A_LO, rd);  chk("R3 lo masked", rd, 8'h0E);
        exp_cur = 7;

        // R7: locked access mode
        wr_reg(A_LO, 8'h02);
        wr_reg(A_HI, 8'h05);
        wr_reg(A_CUR, 8'h02);
        exp_cur = 2;
        wr_reg(A_CTRL, C_LOCK);
        wr_reg(A_LO, 8'h09);
        wr_reg(A_HI, 8'h0C);
        wr_reg(A_CUR, 8'h0B);
        wr_reg(A_PTR, 8'h03);
        wr_reg(A_DATA, 8'hEE);
        rd_reg(A_LO, rd);   chk("R7 lo locked", rd, 8'h02);
        rd_reg(A_HI, rd);   chk("R7 hi locked", rd, 8'h05);
        rd_reg(A_CUR, rd);  chk("R7 cur locked", rd, 8'h02);
        rd_reg(A_PTR, rd);  chk("R7 ptr writable", rd, 8'h03);
        rd_reg(A_DATA, rd); chk("R7 data locked", rd, model[3]);
        cap_and_track(2, 5, 8'h3C);
        rd_reg(A_CUR, rd);  chk("R7 capture while locked", rd, 8'(exp_cur));
        wr_reg(A_STAT, 8'h01);
        rd_reg(A_STAT, rd); chk("R7 status writable", rd, 8'h00);
        wr_reg(A_CTRL, C_RUN);
        rd_reg(A_CTRL, rd); chk("R7 unlock", rd, C_RUN);

        // R1 R2: sweep every span on the small ring
        for (int lo = 0; lo < DEPTH; lo++) begin
            for (int hi = lo; hi < DEPTH; hi++) begin
                wr_reg(A_LO, 8'(lo));
                wr_reg(A_HI, 8'(hi));
                wr_reg(A_CUR, 8'(lo));
                exp_cur = lo;
                for (int k = 0; k <= hi - lo + 1; k++) begin
                    code = 8'((lo * 16 + hi + k * 7) & 8'hFF);
                    cap_and_track(lo, hi, code);
                    rd_reg(A_CUR, rd);
                    chk((exp_cur == lo) ? "R2 fold" : "R1 step", rd, 8'(exp_cur));
                end
            end
        end
        for (int i = 0; i < DEPTH; i++) begin
            wr_reg(A_PTR, 8'(i));
            rd_reg(A_DATA, rd); chk("R1 ring content", rd, model[i]);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule